// File: doc/BRIEF.md
# Bus Setup/Hold Violation Trigger

This block checks every bit of a parallel data bus against programmable setup and hold windows placed around the active edge of an external strobe, such as a memory write-enable or a synchronous memory clock. The bus and the strobe are both sampled on a fast tick clock. One tick is the unit of timing resolution; at 500 ps per tick, a 3.5 ns setup and 1.5 ns hold limit become windows of 7 and 3 ticks. Checking runs on every strobe edge for as long as the block stays armed. It does not need the data to follow a repeating pattern.

When any bit changes inside a window, the block latches a trigger. With it, the block latches the set of bits that moved in that tick and a code naming the window or windows that were hit. A circular history records one bus sample per tick. After the trigger, it keeps writing for a programmed number of further samples and then freezes. The frozen history therefore holds traffic from both before and after the fault. It is read one sample at a time, indexed from the oldest entry. To sweep the windows and find the margin, raise the window by one tick, re-arm, and repeat until the trigger fires.

Top module: `bus_timing_trigger`

## Requirements
- R1: While reset is held, trig_o, cause_o, fault_mask_o and cap_done_o are 0, and every history entry reads as 0.
- R2: The first tick after reset only sets the reference sample. No bus change or strobe edge is seen on that tick, whatever the inputs are.
- R3: An active (rising) strobe edge at tick te is a setup violation for each bit that last changed at a tick tc with te-tc < setup_win_i. A change in the edge tick itself has te-tc = 0. The violation sets cause_o bit 0.
- R4: After an edge at tick te, a change of any bit at a tick in te+1..te+hold_win_i is a hold violation and sets cause_o bit 1. A change at te+hold_win_i+1 is not a violation.
- R5: A window of 0 disables that check. With both windows at 0, no bus or strobe activity raises the trigger.
- R6: On the first violating tick, fault_mask_o takes the OR of the bits violating in that tick. cause_o takes both bits when the setup and hold checks hit in the same tick.
- R7: trig_o stays high until arm_i is sampled high. That tick clears trig_o, fault_mask_o and cause_o, and any violation in the same tick is ignored.
- R8: While triggered, later violations do not change fault_mask_o or cause_o.
- R9: A new active edge during a running hold window restarts the window from that edge.
- R10: The history stores one sample per tick while untriggered. The trigger tick's sample is stored, then exactly post_cnt_i further samples. cap_done_o then goes high and writing stops until re-armed.
- R11: rd_data_o shows the history entry rd_idx_i places after the next write slot. Index 0 is the oldest sample and index 2^AW-1 the newest. When frozen, the trigger sample sits at index 2^AW-1-post_cnt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock; one period is one resolution unit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_i | input | W (32) | Data bus under test |
| strobe_i | input | 1 | Reference strobe; rising edge is active |
| arm_i | input | 1 | Clears the trigger and restarts capture |
| setup_win_i | input | CW (6) | Setup window in ticks |
| hold_win_i | input | CW (6) | Hold window in ticks |
| post_cnt_i | input | AW (4) | Samples kept after the trigger sample |
| rd_idx_i | input | AW (4) | History read index, 0 = oldest |
| trig_o | output | 1 | Latched violation trigger |
| cause_o | output | 2 | Bit 0 setup, bit 1 hold |
| fault_mask_o | output | W (32) | Bits violating on the first fault |
| cap_done_o | output | 1 | History frozen after post-trigger samples |
| rd_data_o | output | W (32) | History sample at rd_idx_i |

## Verification
The assertions assume that bus_i and strobe_i are already synchronous to the tick clock and stay stable between rising edges. They also assume that post_cnt_i is not changed while the post-trigger count is running. The bench drives every input one nanosecond after the falling edge. It changes window and post-count settings only on ticks that a per-tick reference model also sees, so the model and the design always latch the same values at each strobe edge and each trigger.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int unsigned CAUSE_W = 2;
  localparam int unsigned CAUSE_SETUP = 0;
  localparam int unsigned CAUSE_HOLD  = 1;

  typedef logic [CAUSE_W-1:0] cause_t;

  function automatic cause_t mk_cause(input logic setup_hit, input logic hold_hit);
    cause_t c;
    c = '0;
    c[CAUSE_SETUP] = setup_hit;
    c[CAUSE_HOLD]  = hold_hit;
    return c;
  endfunction
endpackage

// File: rtl/bt_setup_chk.sv
module bt_setup_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  chg_i,
  input  logic          edge_i,
  input  logic [CW-1:0] setup_win_i,
  output logic [W-1:0]  viol_o
);
  localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};

  logic win_on;
  assign win_on = (setup_win_i != '0);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [CW-1:0] age_q;  // ticks since last change, saturating

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            age_q <= '1;
      else if (chg_i[g])      age_q <= '0;
      else if (age_q != '1)   age_q <= age_q + 1'b1;
    end

    // distance to edge = age + 1 unless the bit moves in the edge tick
    assign viol_o[g] = edge_i && win_on &&
                       (chg_i[g] || (({1'b0, age_q} + ONE) < {1'b0, setup_win_i}));
  end

  a_r5_setup_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_win_i == '0) |-> (viol_o == '0));
endmodule

// File: rtl/bt_hold_chk.sv
module bt_hold_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  chg_i,
  input  logic          edge_i,
  input  logic [CW-1:0] hold_win_i,
  output logic [W-1:0]  viol_o
);
  logic [CW-1:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hcnt_q <= '0;
    else if (edge_i)        hcnt_q <= hold_win_i;  // restart on each edge
    else if (hcnt_q != '0)  hcnt_q <= hcnt_q - 1'b1;
  end

  assign viol_o = (hcnt_q != '0) ? chg_i : '0;

  a_r4_zero_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && hold_win_i == '0) |=> (viol_o == '0));
endmodule

// File: rtl/bt_history.sv
module bt_history #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  bus_i,
  input  logic          trig_i,
  input  logic          fire_i,
  input  logic          arm_i,
  input  logic [AW-1:0] post_cnt_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o,
  output logic          done_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q;
  logic [AW-1:0] post_q;
  logic [AW-1:0] rd_addr;
  logic          wr_en;

  assign wr_en = !trig_i || (post_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wptr_q <= '0;
    end else if (wr_en) begin
      mem_q[wptr_q] <= bus_i;
      wptr_q        <= wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         post_q <= '0;
    else if (arm_i)                      post_q <= '0;
    else if (fire_i)                     post_q <= post_cnt_i;
    else if (trig_i && post_q != '0)     post_q <= post_q - 1'b1;
  end

  assign rd_addr   = wptr_q + rd_idx_i;
  assign rd_data_o = mem_q[rd_addr];
  assign done_o    = trig_i && (post_q == '0);

  a_r10_frozen_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(wptr_q));
endmodule

// File: rtl/bus_timing_trigger.sv
module bus_timing_trigger
  import bt_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned CW       = 6,
  parameter int unsigned AW       = 4,
  parameter bit          STB_RISE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [W-1:0]       bus_i,
  input  logic               strobe_i,
  input  logic               arm_i,
  input  logic [CW-1:0]      setup_win_i,
  input  logic [CW-1:0]      hold_win_i,
  input  logic [AW-1:0]      post_cnt_i,
  input  logic [AW-1:0]      rd_idx_i,
  output logic               trig_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [W-1:0]       fault_mask_o,
  output logic               cap_done_o,
  output logic [W-1:0]       rd_data_o
);
  logic         primed_q;
  logic [W-1:0] bus_q;
  logic         stb_q;
  logic [W-1:0] chg;
  logic         raw_edge;
  logic         stb_edge;
  logic [W-1:0] s_viol, h_viol, viol;
  logic         fire;
  logic         trig_q;
  cause_t       cause_q;
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      bus_q    <= '0;
      stb_q    <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      bus_q    <= bus_i;
      stb_q    <= strobe_i;
    end
  end

  // first tick after reset is reference only
  assign chg = primed_q ? (bus_i ^ bus_q) : '0;

  if (STB_RISE) begin : g_rise
    assign raw_edge = strobe_i & ~stb_q;
  end else begin : g_fall
    assign raw_edge = ~strobe_i & stb_q;
  end
  assign stb_edge = primed_q & raw_edge;

  bt_setup_chk #(.W(W), .CW(CW)) u_setup (
    .clk_i, .rst_ni, .chg_i(chg), .edge_i(stb_edge),
    .setup_win_i, .viol_o(s_viol)
  );

  bt_hold_chk #(.W(W), .CW(CW)) u_hold (
    .clk_i, .rst_ni, .chg_i(chg), .edge_i(stb_edge),
    .hold_win_i, .viol_o(h_viol)
  );

  assign viol = s_viol | h_viol;
  assign fire = !trig_q && !arm_i && (viol != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q  <= 1'b0;
      cause_q <= '0;
      mask_q  <= '0;
    end else if (arm_i) begin
      trig_q  <= 1'b0;
      cause_q <= '0;
      mask_q  <= '0;
    end else if (fire) begin
      trig_q  <= 1'b1;
      cause_q <= mk_cause(|s_viol, |h_viol);
      mask_q  <= viol;
    end
  end

  bt_history #(.W(W), .AW(AW)) u_hist (
    .clk_i, .rst_ni, .bus_i, .trig_i(trig_q), .fire_i(fire), .arm_i,
    .post_cnt_i, .rd_idx_i, .rd_data_o, .done_o(cap_done_o)
  );

  assign trig_o       = trig_q;
  assign cause_o      = cause_q;
  assign fault_mask_o = mask_q;

  a_r7_trig_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !arm_i) |=> trig_q);

  a_r7_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!trig_q && mask_q == '0));

  a_r8_latch_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !arm_i) |=> ($stable(mask_q) && $stable(cause_q)));

  a_r6_fault_named: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_q) |-> (mask_q != '0 && cause_q != '0));
endmodule

// File: tb/bus_timing_trigger_tb.sv
`timescale 1ns/1ps
module bus_timing_trigger_tb;
  localparam int W = 32, CW = 6, AW = 4, DEPTH = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  bus_i = '0;
  logic          strobe_i = 1'b0, arm_i = 1'b0;
  logic [CW-1:0] setup_win_i = 6'd7, hold_win_i = 6'd3;
  logic [AW-1:0] post_cnt_i = 4'd4, rd_idx_i = '0;
  logic          trig_o, cap_done_o;
  logic [1:0]    cause_o;
  logic [W-1:0]  fault_mask_o, rd_data_o;

  bus_timing_trigger #(.W(W), .CW(CW), .AW(AW)) u_dut (
    .clk_i, .rst_ni, .bus_i, .strobe_i, .arm_i, .setup_win_i, .hold_win_i,
    .post_cnt_i, .rd_idx_i, .trig_o, .cause_o, .fault_mask_o, .cap_done_o, .rd_data_o
  );

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int           m_tick, m_hold_end;
  int           m_last [W];
  logic [W-1:0] m_prev, m_mask;
  logic         m_prev_s, m_primed, m_trig;
  logic [1:0]   m_cause;
  int           m_post;
  logic [W-1:0] m_hist [$];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_tick = 0; m_hold_end = -1; m_prev = '0; m_prev_s = 0; m_primed = 0;
      m_trig = 0; m_mask = '0; m_cause = '0; m_post = 0;
      for (int i = 0; i < W; i++) m_last[i] = -1000;
      m_hist.delete();
      for (int i = 0; i < DEPTH; i++) m_hist.push_back('0);
    end else begin
      logic [W-1:0] chg, vs, vh;
      logic         edg;
      vs = '0; vh = '0;
      if (m_primed) begin
        chg = bus_i ^ m_prev;
        edg = strobe_i && !m_prev_s;
        if (m_tick <= m_hold_end) vh = chg;
        if (edg) begin
          for (int i = 0; i < W; i++) begin
            int d;
            d = chg[i] ? 0 : (m_tick - m_last[i]);
            if (d < int'(setup_win_i)) vs[i] = 1'b1;
          end
          m_hold_end = m_tick + int'(hold_win_i);
        end
        for (int i = 0; i < W; i++) if (chg[i]) m_last[i] = m_tick;
      end
      m_prev = bus_i; m_prev_s = strobe_i; m_primed = 1;
      if (!m_trig || m_post != 0) begin
        m_hist.push_back(bus_i);
        void'(m_hist.pop_front());
      end
      if (arm_i) begin
        m_trig = 0; m_mask = '0; m_cause = '0; m_post = 0;
      end else if (!m_trig && (vs | vh) != '0) begin
        m_trig = 1; m_mask = vs | vh; m_cause = {|vh, |vs}; m_post = int'(post_cnt_i);
      end else if (m_trig && m_post != 0) begin
        m_post--;
      end
      m_tick++;
    end
  end

  bit model_on = 0;
  always @(negedge clk_i) begin
    if (model_on) begin
      chk("R7 model trig", {31'd0, trig_o}, {31'd0, m_trig});
      chk("R6 model mask", fault_mask_o, m_mask);
      chk("R3 model cause", {30'd0, cause_o}, {30'd0, m_cause});
      chk("R10 model done", {31'd0, cap_done_o}, {31'd0, (m_trig && m_post == 0)});
      chk("R11 model history", rd_data_o, m_hist[rd_idx_i]);
    end
  end

  // ---------------- stimulus ----------------
  logic [W-1:0] cur_b;

  task automatic step(input logic [W-1:0] b, input logic s, input logic a);
    bus_i = b; strobe_i = s; arm_i = a; cur_b = b;
    @(negedge clk_i); #1;
  endtask

  task automatic quiet(input int n, input logic s);
    repeat (n) step(cur_b, s, 1'b0);
  endtask

  task automatic rd_chk(input string tag, input int idx, input logic [W-1:0] exp);
    rd_idx_i = AW'(idx); #1;
    chk(tag, rd_data_o, exp);
    rd_idx_i = '0; #1;
  endtask

  task automatic latch_chk(input string tag, input logic t, input logic [1:0] c, input logic [W-1:0] m);
    chk({tag, " trig"}, {31'd0, trig_o}, {31'd0, t});
    chk({tag, " cause"}, {30'd0, cause_o}, {30'd0, c});
    chk({tag, " mask"}, fault_mask_o, m);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bus_i = 32'hA5A5_0F0F; strobe_i = 1'b1; cur_b = bus_i;
    model_on = 1;
    repeat (3) @(negedge clk_i);
    #1;
    // R1: reset state
    latch_chk("R1 reset", 1'b0, 2'b00, '0);
    chk("R1 reset done", {31'd0, cap_done_o}, 32'd0);
    rd_chk("R1 reset history", 7, '0);
    rst_ni = 1'b1;

    // R2: nonzero bus and high strobe on first tick are reference only
    quiet(3, 1'b1);
    chk("R2 first tick reference", {31'd0, trig_o}, 32'd0);
    quiet(10, 1'b0);

    // R3 setup hit at distance 3, then R8 and R10/R11
    begin
      logic [W-1:0] b1, b2;
      b1 = cur_b ^ (32'd1 << 5);
      step(b1, 0, 0); step(b1, 0, 0); step(b1, 0, 0); step(b1, 1, 0);
      latch_chk("R3 setup hit", 1'b1, 2'b01, 32'd1 << 5);
      b2 = b1 ^ (32'd1 << 9);
      step(b2, 1, 0);  // hold-window change after latch
      latch_chk("R8 later fault ignored", 1'b1, 2'b01, 32'd1 << 5);
      step(b2, 1, 0); step(b2, 1, 0);
      chk("R10 still capturing", {31'd0, cap_done_o}, 32'd0);
      step(b2, 1, 0);
      chk("R10 capture done", {31'd0, cap_done_o}, 32'd1);
      step(~b2, 0, 0);
      chk("R10 done stays", {31'd0, cap_done_o}, 32'd1);
      rd_chk("R10 writing stopped", 15, b2);
      rd_chk("R11 trigger sample slot", 11, b1);
      rd_chk("R11 pre-trigger sample", 10, b1);
      rd_chk("R11 post-trigger sample", 12, b2);
    end

    step(cur_b, 0, 1);
    latch_chk("R7 arm clears", 1'b0, 2'b00, '0);
    chk("R7 arm clears done", {31'd0, cap_done_o}, 32'd0);
    quiet(10, 1'b0);

    // R4 hold boundary: change at te+H+1 passes
    step(cur_b, 1, 0); quiet(3, 1'b1);
    step(cur_b ^ (32'd1 << 19), 1, 0);
    chk("R4 hold edge+H+1 clean", {31'd0, trig_o}, 32'd0);
    quiet(10, 1'b0);

    // R4 hold hit at te+2
    step(cur_b, 1, 0); step(cur_b, 1, 0);
    step(cur_b ^ (32'd1 << 19), 1, 0);
    latch_chk("R4 hold hit", 1'b1, 2'b10, 32'd1 << 19);
    step(cur_b, 0, 1); quiet(10, 1'b0);

    // R3 setup boundary: distance S passes, S-1 fails
    step(cur_b ^ 32'd1, 0, 0); quiet(6, 1'b0); step(cur_b, 1, 0);
    chk("R3 setup distance S clean", {31'd0, trig_o}, 32'd0);
    quiet(10, 1'b0);
    step(cur_b ^ 32'd1, 0, 0); quiet(5, 1'b0); step(cur_b, 1, 0);
    latch_chk("R3 setup distance S-1", 1'b1, 2'b01, 32'd1);
    step(cur_b, 0, 1); quiet(10, 1'b0);

    // R3 change in edge tick
    step(cur_b ^ (32'd1 << 31), 1, 0);
    latch_chk("R3 same tick change", 1'b1, 2'b01, 32'd1 << 31);
    step(cur_b, 0, 1); quiet(10, 1'b0);

    // R9 second edge restarts hold window
    step(cur_b, 1, 0); step(cur_b, 0, 0); step(cur_b, 1, 0); quiet(2, 1'b1);
    step(cur_b ^ (32'd1 << 7), 1, 0);
    latch_chk("R9 hold restart", 1'b1, 2'b10, 32'd1 << 7);
    step(cur_b, 0, 1); quiet(10, 1'b0);

    // R6 setup and hold in one tick
    step(cur_b, 1, 0); step(cur_b, 0, 0);
    step(cur_b ^ (32'd1 << 3), 1, 0);
    latch_chk("R6 both causes", 1'b1, 2'b11, 32'd1 << 3);
    step(cur_b, 0, 1); quiet(10, 1'b0);

    // R5 windows at zero
    setup_win_i = '0; hold_win_i = '0;
    quiet(2, 1'b0);
    step(cur_b ^ 32'd2, 1, 0); step(cur_b ^ 32'd4, 1, 0);
    chk("R5 zero windows", {31'd0, trig_o}, 32'd0);
    setup_win_i = 6'd7; hold_win_i = 6'd3;
    quiet(10, 1'b0);

    // R7 violation on arm tick ignored
    step(cur_b ^ (32'd1 << 8), 1, 1);
    chk("R7 arm tick violation ignored", {31'd0, trig_o}, 32'd0);
    quiet(10, 1'b0);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] b;
      logic s, a;
      b = cur_b;
      if ($urandom_range(5) == 0) b = b ^ (32'd1 << $urandom_range(W - 1));
      s = strobe_i;
      if ($urandom_range(3) == 0) s = ~s;
      a = (n % 97) == 96;
      if (n % 200 == 0) begin
        setup_win_i = CW'($urandom_range(11));
        hold_win_i  = CW'($urandom_range(7));
        post_cnt_i  = AW'($urandom_range(15));
      end
      rd_idx_i = AW'($urandom_range(DEPTH - 1));
      step(b, s, a);
    end

    model_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule